// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Bank

This block keeps the six low bits of the normal interrupt status word of an SD host controller. The host engine reports activity to it in two ways. Two level flags, buffer-read-enable and buffer-write-enable, raise a status bit on their 0-to-1 transitions. One-cycle pulses report command completion, data-transfer and busy completion, a halt at a block gap, a DMA buffer boundary crossing and the completion of a tuning command. Context inputs decide which pulses latch. Tuning mode suppresses transfer completion and routes tuning-command completion to the read-ready bit. A stop-at-gap request is needed before a gap halt counts. A flag that marks a response as belonging to an automatically issued stop or block-count command keeps that response out of command-complete.

Software reads the bank over a simple 32-bit register port at offset 0x30. It clears bits by writing ones to them. If a hardware set and a clear hit the same bit in the same cycle, the set wins. A status-enable mask decides which events latch at all. A separate signal-enable mask decides which latched bits drive the interrupt line.

Top module: `sdh_irq_status`

## Requirements
- R1: After a synchronous active-low reset, all six status bits are 0, the interrupt output is 0 and a read at offset 0x30 returns 0.
- R2: A read at offset 0x30 returns the status in bits [5:0] in the order command complete (0), transfer complete (1), block gap (2), DMA boundary (3), write ready (4), read ready (5). Bits [31:6] read 0. A read at any other offset returns 0.
- R3: A command-response-end pulse sets bit 0 on the next clock edge, unless the response is flagged as an automatic stop or block-count response, in which case bit 0 is not set.
- R4: A data-transfer-done pulse or a busy-command-done pulse sets bit 1, except while tuning mode is active, when neither sets it.
- R5: A gap-halt pulse sets bit 2 only while the stop-at-gap request input is 1.
- R6: A DMA boundary pulse sets bit 3.
- R7: Bit 4 sets only on a 0-to-1 transition of the buffer-write-enable level, and bit 5 sets only on such a transition of the buffer-read-enable level. A level held high does not set the bit again after the bit is cleared.
- R8: While tuning mode is active, a tuning-command-done pulse sets bit 5. Outside tuning mode the pulse has no effect.
- R9: A write at offset 0x30 clears each status bit whose data bit is 1. Bits written with 0 are unchanged, and a write at any other offset changes nothing.
- R10: When a set event and a write-one-to-clear reach the same bit in the same cycle, the bit ends up 1.
- R11: An event latches only if its bit in the status-enable mask is 1. The interrupt output is 1 exactly when some status bit is 1 and its signal-enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_rd_en_lvl | input | 1 | Buffer-read-enable level from the present-state logic |
| buf_wr_en_lvl | input | 1 | Buffer-write-enable level from the present-state logic |
| cmd_resp_end | input | 1 | Pulse: end bit of a command response received |
| cmd_resp_auto | input | 1 | Qualifies cmd_resp_end as an automatic stop or block-count response |
| xfer_done | input | 1 | Pulse: data transfer finished |
| busy_cmd_done | input | 1 | Pulse: command with busy signalling finished |
| gap_halt | input | 1 | Pulse: transaction halted at a block gap |
| stop_gap_req | input | 1 | Stop-at-block-gap request level |
| dma_bndry | input | 1 | Pulse: DMA buffer boundary reached |
| tune_active | input | 1 | Tuning procedure in progress |
| tune_cmd_done | input | 1 | Pulse: a tuning command completed |
| stat_en | input | 6 | Per-bit status-enable mask |
| sig_en | input | 6 | Per-bit interrupt signal-enable mask |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the collision of a hardware set with a write-one-to-clear. A bank that lets the clear win would lose the event and read 0 where 1 is expected. Read-ready and write-ready are checked with levels held high across a clear. A design that latched the level rather than its edge would set the bit again at once. Tuning mode is exercised with transfer-done and tuning-command-done pulses together, which catches both a missing suppression of bit 1 and a missing route to bit 5. Automatic-response flags, stop-at-gap gating, zero writes and writes at a foreign offset cover the remaining places where an event or a write must have no effect.

// File: rtl/sdh_irq_pkg.sv
`timescale 1ns/1ps
// Package: bit positions and vector type shared by the status bank.
// Assumes the six normal-status bits occupy the low end of the word.
package sdh_irq_pkg;
    localparam int NBITS   = 6;
    localparam int B_CMD   = 0;
    localparam int B_XFER  = 1;
    localparam int B_GAP   = 2;
    localparam int B_DMA   = 3;
    localparam int B_WRRDY = 4;
    localparam int B_RDRDY = 5;
    localparam int NLVL    = 2;
    localparam int L_WR    = 0;
    localparam int L_RD    = 1;
    typedef logic [NBITS-1:0] stat_vec_t;
endpackage

// File: rtl/sdh_rise_detect.sv
`timescale 1ns/1ps
// Module: sdh_rise_detect
// Flags a one-cycle rise for each level input that was low last cycle and
// is high now. Assumes the inputs are synchronous to clk. The history
// resets to 0, so a level already high when reset ends counts as a rise.
module sdh_rise_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_lane
        // Purpose: remember the level of the previous cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end

        // Purpose: report a rise when the level goes from low to high.
        always_comb rise[i] = lvl[i] & ~prev_q[i];

        // R7: a level cannot rise in two consecutive cycles
        a_r7_no_double_rise: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/sdh_event_qualify.sv
`timescale 1ns/1ps
// Module: sdh_event_qualify
// Turns raw engine pulses and level rises into per-bit set requests,
// applying the context gating: automatic responses, tuning mode and the
// stop-at-gap request. Purely combinational; all inputs share one clock.
module sdh_event_qualify
    import sdh_irq_pkg::*;
(
    input  logic            cmd_resp_end,
    input  logic            cmd_resp_auto,
    input  logic            xfer_done,
    input  logic            busy_cmd_done,
    input  logic            gap_halt,
    input  logic            stop_gap_req,
    input  logic            dma_bndry,
    input  logic            tune_active,
    input  logic            tune_cmd_done,
    input  logic [NLVL-1:0] lvl_rise,
    input  stat_vec_t       stat_en,
    output stat_vec_t       set_req
);
    stat_vec_t raw;

    // Purpose: qualify each event source by its context.
    always_comb begin
        raw          = '0;
        raw[B_CMD]   = cmd_resp_end & ~cmd_resp_auto;
        raw[B_XFER]  = (xfer_done | busy_cmd_done) & ~tune_active;
        raw[B_GAP]   = gap_halt & stop_gap_req;
        raw[B_DMA]   = dma_bndry;
        raw[B_WRRDY] = lvl_rise[L_WR];
        raw[B_RDRDY] = lvl_rise[L_RD] | (tune_active & tune_cmd_done);
    end

    // Purpose: drop events whose status-enable bit is off.
    always_comb set_req = raw & stat_en;
endmodule

// File: rtl/sdh_w1c_bank.sv
`timescale 1ns/1ps
// Module: sdh_w1c_bank
// A row of sticky status flops. Each bit sets on its set request and
// clears on its clear request. A set in the same cycle as a clear wins.
module sdh_w1c_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: sticky bit with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (set_v[i]) q[i] <= 1'b1;
            else if (clr_v[i]) q[i] <= 1'b0;
        end

        // R10: a set is never lost, even against a clear
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> q[i]);
        // R9: a clear without a set empties the bit
        a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[i] && !set_v[i]) |=> !q[i]);
        // R9: a bit only rises through a set request
        a_r9_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
            !set_v[i] |=> !$rose(q[i]));
    end
endmodule

// File: rtl/sdh_irq_status.sv
`timescale 1ns/1ps
// Module: sdh_irq_status (top)
// Normal interrupt status bits of an SD host. Combines level-edge
// detection, event qualification and a write-one-to-clear bank, and
// serves a 32-bit register port with single-cycle writes and
// combinational reads. Assumes one clock domain and synchronous reset.
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 32,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_rd_en_lvl,
    input  logic              buf_wr_en_lvl,
    input  logic              cmd_resp_end,
    input  logic              cmd_resp_auto,
    input  logic              xfer_done,
    input  logic              busy_cmd_done,
    input  logic              gap_halt,
    input  logic              stop_gap_req,
    input  logic              dma_bndry,
    input  logic              tune_active,
    input  logic              tune_cmd_done,
    input  logic [NBITS-1:0]  stat_en,
    input  logic [NBITS-1:0]  sig_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NBITS;

    logic [NLVL-1:0] lvl_in;
    logic [NLVL-1:0] lvl_rise;
    stat_vec_t       set_req;
    stat_vec_t       clr_req;
    stat_vec_t       stat_q;
    logic            hit;

    // Purpose: gather the level flags in package lane order.
    always_comb begin
        lvl_in       = '0;
        lvl_in[L_WR] = buf_wr_en_lvl;
        lvl_in[L_RD] = buf_rd_en_lvl;
    end

    sdh_rise_detect #(.N(NLVL)) u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl_in),
        .rise (lvl_rise)
    );

    sdh_event_qualify u_qual (
        .cmd_resp_end (cmd_resp_end),
        .cmd_resp_auto(cmd_resp_auto),
        .xfer_done    (xfer_done),
        .busy_cmd_done(busy_cmd_done),
        .gap_halt     (gap_halt),
        .stop_gap_req (stop_gap_req),
        .dma_bndry    (dma_bndry),
        .tune_active  (tune_active),
        .tune_cmd_done(tune_cmd_done),
        .lvl_rise     (lvl_rise),
        .stat_en      (stat_en),
        .set_req      (set_req)
    );

    // Purpose: decode the register offset.
    always_comb hit = (bus_addr == REG_OFS);

    // Purpose: turn a write at the status offset into per-bit clears.
    always_comb clr_req = (bus_wr && hit) ? bus_wdata[NBITS-1:0] : '0;

    sdh_w1c_bank #(.N(NBITS)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .set_v(set_req),
        .clr_v(clr_req),
        .q    (stat_q)
    );

    // Purpose: combinational read with zero-filled upper bits.
    always_comb bus_rdata = hit ? {{PAD_W{1'b0}}, stat_q} : '0;

    // Purpose: interrupt is any status bit that is also signal-enabled.
    always_comb irq = |(stat_q & sig_en);

    // R4: tuning mode keeps transfer-complete from rising
    a_r4_tune_blocks_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        tune_active |=> !$rose(stat_q[B_XFER]));
    // R5: no block gap event without a stop request
    a_r5_gap_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_gap_req |=> !$rose(stat_q[B_GAP]));
    // R3: automatic responses never raise command complete
    a_r3_auto_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_resp_end || cmd_resp_auto) |=> !$rose(stat_q[B_CMD]));
    // R3: a qualifying response end is latched
    a_r3_cmd_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_resp_end && !cmd_resp_auto && stat_en[B_CMD]) |=> stat_q[B_CMD]);
    // R11: a fully masked signal enable keeps the line quiet
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en == '0) |-> !irq);
    // R1: the bank is empty on the first cycle after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '0));
endmodule

// File: tb/tb_sdh_irq_status.sv
`timescale 1ns/1ps
module tb_sdh_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_lvl = 0, wr_lvl = 0, cmd_end = 0, cmd_auto = 0;
    logic        xdone = 0, bdone = 0, ghalt = 0, sreq = 0, dmab = 0;
    logic        tune = 0, tdone = 0, bwr = 0;
    logic [5:0]  sten = '1, sgen = '1;
    logic [7:0]  addr = 8'h30;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0, nerr = 0;
    logic [5:0] m_stat = '0;
    logic       m_prd = 0, m_pwr = 0;

    always #4 clk = ~clk;

    sdh_irq_status dut (
        .clk(clk), .rst_n(rst_n), .buf_rd_en_lvl(rd_lvl), .buf_wr_en_lvl(wr_lvl),
        .cmd_resp_end(cmd_end), .cmd_resp_auto(cmd_auto), .xfer_done(xdone),
        .busy_cmd_done(bdone), .gap_halt(ghalt), .stop_gap_req(sreq),
        .dma_bndry(dmab), .tune_active(tune), .tune_cmd_done(tdone),
        .stat_en(sten), .sig_en(sgen), .bus_wr(bwr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    task automatic ch(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected set vector, written from the requirements.
    function automatic logic [5:0] sets();
        logic [5:0] s;
        s[0] = cmd_end & ~cmd_auto;                 // R3
        s[1] = (xdone | bdone) & ~tune;             // R4
        s[2] = ghalt & sreq;                        // R5
        s[3] = dmab;                                // R6
        s[4] = wr_lvl & ~m_pwr;                     // R7
        s[5] = (rd_lvl & ~m_prd) | (tune & tdone);  // R7, R8
        return s & sten;                            // R11
    endfunction

    // One clock with the current inputs, then compare against the model.
    task automatic cyc(input string tag);
        logic [5:0] clr, nxt;
        clr = (bwr && addr == 8'h30) ? wdata[5:0] : 6'h0;  // R9
        nxt = (m_stat & ~clr) | sets();                     // R10
        @(posedge clk); #2;
        m_stat = nxt; m_prd = rd_lvl; m_pwr = wr_lvl;
        ch({tag, " rdata"}, rdata, (addr == 8'h30) ? {26'h0, m_stat} : 32'h0);
        ch({tag, " irq"}, {31'h0, irq}, {31'h0, |(m_stat & sgen)});
        cmd_end = 0; cmd_auto = 0; xdone = 0; bdone = 0; ghalt = 0;
        dmab = 0; tdone = 0; bwr = 0; wdata = '0; addr = 8'h30;
    endtask

    task automatic clr_all();
        bwr = 1; wdata = 32'h3F; cyc("R9 clear all");
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2; rst_n = 1;
        ch("R1 reset rdata", rdata, 32'h0);
        ch("R1 reset irq", {31'h0, irq}, 32'h0);

        cmd_end = 1; cyc("R3 cmd");
        ch("R3 bit0 set", {31'h0, rdata[0]}, 32'h1);
        clr_all();
        cmd_end = 1; cmd_auto = 1; cyc("R3 auto");
        ch("R3 auto ignored", rdata, 32'h0);

        xdone = 1; cyc("R4 xfer");
        ch("R4 bit1", rdata, 32'h2);
        clr_all();
        bdone = 1; cyc("R4 busy");
        ch("R4 busy bit1", rdata, 32'h2);
        clr_all();
        tune = 1; xdone = 1; tdone = 1; cyc("R8 tune");
        ch("R4 R8 tuning", rdata, 32'h20);
        clr_all();
        tune = 0; tdone = 1; cyc("R8 off");
        ch("R8 no tune", rdata, 32'h0);

        ghalt = 1; cyc("R5 nostop");
        ch("R5 no stop", rdata, 32'h0);
        sreq = 1; ghalt = 1; cyc("R5 stop");
        ch("R5 stop", rdata, 32'h4);
        sreq = 0; clr_all();

        dmab = 1; cyc("R6 dma");
        ch("R6 bit3", rdata, 32'h8);
        clr_all();

        wr_lvl = 1; cyc("R7 wr rise");
        ch("R7 bit4", rdata, 32'h10);
        clr_all(); cyc("R7 hold");
        ch("R7 held high", rdata, 32'h0);
        rd_lvl = 1; cyc("R7 rd rise");
        ch("R7 bit5", rdata, 32'h20);
        wr_lvl = 0; rd_lvl = 0; clr_all();

        dmab = 1; xdone = 1; cyc("R9 fill");
        bwr = 1; wdata = 32'hFFFF_FFC0; cyc("R9 zeros");
        ch("R9 zero write", rdata, 32'hA);
        bwr = 1; addr = 8'h34; wdata = 32'h3F; cyc("R2 other ofs");
        ch("R2 foreign read", rdata, 32'h0);
        cyc("R9 foreign"); ch("R9 foreign write", rdata, 32'hA);
        bwr = 1; wdata = 32'h8; cyc("R9 one");
        ch("R9 clear bit3", rdata, 32'h2);

        bwr = 1; wdata = 32'h2; xdone = 1; cyc("R10 collide");
        ch("R10 set wins", rdata, 32'h2);
        clr_all();

        sten = 6'h37; dmab = 1; cyc("R11 sten");
        ch("R11 masked latch", rdata, 32'h0);
        sten = '1; sgen = 6'h00; dmab = 1; cyc("R11 sgen0");
        ch("R11 irq off", {31'h0, irq}, 32'h0);
        sgen = 6'h08; cyc("R11 sgen1");
        ch("R11 irq on", {31'h0, irq}, 32'h1);
        sgen = '1; clr_all();

        void'($urandom(32'd1234));
        for (int k = 0; k < 3000; k++) begin
            cmd_end = ($urandom % 4) == 0; cmd_auto = ($urandom % 3) == 0;
            xdone = ($urandom % 5) == 0;   bdone = ($urandom % 7) == 0;
            ghalt = ($urandom % 5) == 0;   sreq = $urandom % 2;
            dmab = ($urandom % 6) == 0;    tune = ($urandom % 4) == 0;
            tdone = ($urandom % 3) == 0;
            if (($urandom % 4) == 0) rd_lvl = ~rd_lvl;
            if (($urandom % 4) == 0) wr_lvl = ~wr_lvl;
            sten = (($urandom % 5) == 0) ? 6'($urandom) : 6'h3F;
            sgen = 6'($urandom);
            bwr = ($urandom % 3) == 0; wdata = $urandom;
            addr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h30;
            cyc("R2 R9 R10 R11 random");
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule